// File: doc/BRIEF.md
# World-Tagged Section Translation Buffer

This block is a small fully associative translation buffer for a processor core that runs in one of two security worlds, secure or non-secure. It translates 1 MB sections of a 32-bit virtual address space. Every entry records the world that was active when it was written, and a lookup can only hit an entry owned by the world that is current at the time of the lookup. Each entry also stores a separate access-security bit. This bit tells the outgoing memory access whether it must use a secure or a non-secure bus transaction.

A lookup presents a virtual address together with the current world, and gets back a hit flag, the physical address and the access-security bit in the same cycle. After a miss, a table walker supplies the virtual section tag, the physical section base and the security bit taken from the first-level section descriptor. That security bit covers the whole section, and also every page that the descriptor's second-level table would map. Only secure-world fills keep the descriptor's bit. Non-secure-world fills always store "non-secure". A separate output tells the walker which security type to use for its own table reads. This is always the current world, because the walker has no descriptor yet that could tell it otherwise.

Flushes clear either the entries of one world or all entries. A response-error input turns a rejected access into an abort indication, and the block never retries the access with the other security type.

Top module: `sec_tlb`

## Requirements
- R1: A lookup hits in the same cycle when a valid entry has a tag equal to `lkVa[31:20]` and a world tag equal to `worldNs` (0 = secure, 1 = non-secure). On a hit, `lkPa` = {stored base, `lkVa[19:0]`}. On a miss, `lkHit`=0, `lkPa`=0 and `lkNs`=1.
- R2: A fill writes an entry at the rising edge where `fillEn`=1. The entry's world tag is `worldNs` at that edge, and it is visible to lookups from the next cycle.
- R3: An entry owned by one world never hits for a lookup made in the other world.
- R4: A fill made in the secure world stores `fillNs` as the entry's access-security bit. `lkNs` returns that bit on a hit (0 = secure access, 1 = non-secure access).
- R5: A fill made in the non-secure world ignores `fillNs` and stores 1, so every non-secure-world hit reports `lkNs`=1.
- R6: `walkNs` always equals `worldNs`: table reads are secure in the secure world and non-secure in the non-secure world.
- R7: A fill whose tag and world match an existing valid entry overwrites that entry, so lookups return the newest base and security bit and no duplicate entry exists.
- R8: A fill that matches no entry goes to the slot named by a round-robin pointer. The pointer counts 0 to 7 and wraps, and it advances only on such fills, so the ninth distinct fill replaces the first one.
- R9: `flushWorld`=1 invalidates only the entries whose world tag equals `flushWorldNs`.
- R10: `flushAll`=1 invalidates every entry. A fill in the same cycle as any flush is still valid afterwards.
- R11: Reset (`rstN`=0) invalidates every entry and sets the round-robin pointer to slot 0.
- R12: `rspValid`=1 with `rspErr`=1 raises `abortReq` for exactly the next cycle. A response without error raises nothing, and neither kind of response changes the stored translations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| worldNs | input | 1 | Current world, 1 = non-secure |
| lkVa | input | 32 | Lookup virtual address |
| lkHit | output | 1 | Lookup hit |
| lkPa | output | 32 | Translated physical address |
| lkNs | output | 1 | Access-security bit for the outgoing access |
| walkNs | output | 1 | Security type for table-walk reads |
| fillEn | input | 1 | Write a translation at the next edge |
| fillTag | input | 12 | Virtual section tag of the fill |
| fillBase | input | 12 | Physical section base from the descriptor |
| fillNs | input | 1 | Security bit from the descriptor |
| flushWorld | input | 1 | Invalidate the entries of one world |
| flushWorldNs | input | 1 | World selected for `flushWorld` |
| flushAll | input | 1 | Invalidate every entry |
| rspValid | input | 1 | Access response present |
| rspErr | input | 1 | Response signals a security-type rejection |
| abortReq | output | 1 | Abort indication, one cycle after an error response |

## Verification
The hardest case to reach from the ports is two live entries that share a virtual tag but belong to different worlds. One of these worlds is then flushed, or an entry is overwritten while it is being flushed in the same cycle. Random fills rarely build that state, because the round-robin pointer keeps evicting older entries. Directed steps therefore fill the same tag from both worlds, rewrite it, flush one world, and combine a flush-all with a fill in the same cycle. After that, a long random phase draws from a pool of twelve tags and both worlds, which forces evictions and cross-world tag collisions, and it checks every lookup against a reference model.

// File: rtl/sec_tlb_pkg.sv
package sec_tlb_pkg;

  // Strobes from the control half to the entry array.
  typedef struct packed {
    logic wrEn;    // write the entry selected by wrIdx
    logic wrNs;    // access-security bit to store
    logic clrSec;  // invalidate secure-owned entries
    logic clrNsec; // invalidate non-secure-owned entries
  } tlbStrobe_t;

endpackage

// File: rtl/sec_tlb_ctrl.sv
module sec_tlb_ctrl
  import sec_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               worldNs,
  input  logic               fillEn,
  input  logic               fillNs,
  input  logic               flushWorld,
  input  logic               flushWorldNs,
  input  logic               flushAll,
  input  logic [ENTRIES-1:0] fillMatch,
  input  logic               rspValid,
  input  logic               rspErr,
  output tlbStrobe_t         strobe,
  output logic [IDX_W-1:0]   wrIdx,
  output logic               abortReq
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] matchIdx;
  logic             anyMatch;

  // Encode the (at most one-hot) match vector.
  always_comb begin
    matchIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (fillMatch[i]) matchIdx = IDX_W'(i);
    end
  end

  assign anyMatch = |fillMatch;
  assign wrIdx    = anyMatch ? matchIdx : rrPtr;

  always_comb begin
    strobe.wrEn    = fillEn;
    // Non-secure fills always store the non-secure attribute.
    strobe.wrNs    = worldNs | fillNs;
    strobe.clrSec  = flushAll | (flushWorld & ~flushWorldNs);
    strobe.clrNsec = flushAll | (flushWorld & flushWorldNs);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (fillEn && !anyMatch) begin
      rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
    end
  end

  // A rejected access becomes an abort; no retry is attempted.
  always_ff @(posedge clk) begin
    if (!rstN) abortReq <= 1'b0;
    else       abortReq <= rspValid & rspErr;
  end

endmodule

// File: rtl/sec_tlb_dp.sv
module sec_tlb_dp
  import sec_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int OFS_W   = 20,
  localparam int TAG_W  = ADDR_W - OFS_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbStrobe_t         strobe,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [TAG_W-1:0]   wrTag,
  input  logic [TAG_W-1:0]   wrBase,
  input  logic               wrWorld,
  input  logic [ADDR_W-1:0]  lkVa,
  input  logic               lkWorld,
  output logic               lkHit,
  output logic [ADDR_W-1:0]  lkPa,
  output logic               lkNs,
  output logic [ENTRIES-1:0] fillMatch
);

  logic [ENTRIES-1:0] entValid;
  logic [ENTRIES-1:0] entNs;
  logic [ENTRIES-1:0] entWorld;
  logic [TAG_W-1:0]   entTag  [ENTRIES];
  logic [TAG_W-1:0]   entBase [ENTRIES];

  logic [ENTRIES-1:0] hitVec;
  logic [TAG_W-1:0]   hitBase;
  logic               hitNs;
  logic [TAG_W-1:0]   lkTag;

  assign lkTag = lkVa[ADDR_W-1:OFS_W];

  // Per-entry comparators for lookup and for fill de-duplication.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hitVec[g]    = entValid[g] && (entTag[g] == lkTag)
                          && (entWorld[g] == lkWorld);
    assign fillMatch[g] = entValid[g] && (entTag[g] == wrTag)
                          && (entWorld[g] == wrWorld);
  end

  // AND-OR read mux; at most one entry hits.
  always_comb begin
    lkHit   = 1'b0;
    hitBase = '0;
    hitNs   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) begin
        lkHit   = 1'b1;
        hitBase = hitBase | entBase[i];
        hitNs   = hitNs | entNs[i];
      end
    end
  end

  assign lkPa = lkHit ? {hitBase, lkVa[OFS_W-1:0]} : '0;
  assign lkNs = lkHit ? hitNs : 1'b1;

  // Entry storage: a fill wins over a flush of the same slot.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      entNs    <= '0;
      entWorld <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        entTag[i]  <= '0;
        entBase[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobe.wrEn && (wrIdx == IDX_W'(i))) begin
          entValid[i] <= 1'b1;
          entTag[i]   <= wrTag;
          entBase[i]  <= wrBase;
          entNs[i]    <= strobe.wrNs;
          entWorld[i] <= wrWorld;
        end else if ((strobe.clrSec && !entWorld[i]) ||
                     (strobe.clrNsec && entWorld[i])) begin
          entValid[i] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/sec_tlb.sv
module sec_tlb
  import sec_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int OFS_W   = 20,
  localparam int TAG_W  = ADDR_W - OFS_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              worldNs,
  input  logic [ADDR_W-1:0] lkVa,
  output logic              lkHit,
  output logic [ADDR_W-1:0] lkPa,
  output logic              lkNs,
  output logic              walkNs,
  input  logic              fillEn,
  input  logic [TAG_W-1:0]  fillTag,
  input  logic [TAG_W-1:0]  fillBase,
  input  logic              fillNs,
  input  logic              flushWorld,
  input  logic              flushWorldNs,
  input  logic              flushAll,
  input  logic              rspValid,
  input  logic              rspErr,
  output logic              abortReq
);

  tlbStrobe_t         strobe;
  logic [IDX_W-1:0]   wrIdx;
  logic [ENTRIES-1:0] fillMatch;

  // Table reads carry the security type of the current world.
  assign walkNs = worldNs;

  sec_tlb_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .worldNs     (worldNs),
    .fillEn      (fillEn),
    .fillNs      (fillNs),
    .flushWorld  (flushWorld),
    .flushWorldNs(flushWorldNs),
    .flushAll    (flushAll),
    .fillMatch   (fillMatch),
    .rspValid    (rspValid),
    .rspErr      (rspErr),
    .strobe      (strobe),
    .wrIdx       (wrIdx),
    .abortReq    (abortReq)
  );

  sec_tlb_dp #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrIdx    (wrIdx),
    .wrTag    (fillTag),
    .wrBase   (fillBase),
    .wrWorld  (worldNs),
    .lkVa     (lkVa),
    .lkWorld  (worldNs),
    .lkHit    (lkHit),
    .lkPa     (lkPa),
    .lkNs     (lkNs),
    .fillMatch(fillMatch)
  );

endmodule

// File: rtl/sec_tlb_chk.sv
module sec_tlb_chk #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 20,
  localparam int TAG_W = ADDR_W - OFS_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              worldNs,
  input logic [ADDR_W-1:0] lkVa,
  input logic              lkHit,
  input logic [ADDR_W-1:0] lkPa,
  input logic              lkNs,
  input logic              fillEn,
  input logic [TAG_W-1:0]  fillTag,
  input logic              fillNs,
  input logic              rspValid,
  input logic              rspErr,
  input logic              abortReq
);

  a_r1_offset_passes: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> (lkPa[OFS_W-1:0] == lkVa[OFS_W-1:0]));

  a_r1_miss_outputs: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> (lkPa == '0 && lkNs));

  a_r2_fill_visible: assert property (@(posedge clk) disable iff (!rstN)
    fillEn |=> (!(lkVa[ADDR_W-1:OFS_W] == $past(fillTag) &&
                  worldNs == $past(worldNs)) || lkHit));

  a_r4_secure_ns_kept: assert property (@(posedge clk) disable iff (!rstN)
    (fillEn && !worldNs) |=> (!(lkVa[ADDR_W-1:OFS_W] == $past(fillTag) &&
                                !worldNs) || (lkNs == $past(fillNs))));

  a_r5_nsworld_nonsecure: assert property (@(posedge clk) disable iff (!rstN)
    (worldNs && lkHit) |-> lkNs);

  a_r12_abort_follows: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |=> abortReq);

  a_r12_no_spurious_abort: assert property (@(posedge clk) disable iff (!rstN)
    !(rspValid && rspErr) |=> !abortReq);

endmodule

bind sec_tlb sec_tlb_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .worldNs (worldNs),
  .lkVa    (lkVa),
  .lkHit   (lkHit),
  .lkPa    (lkPa),
  .lkNs    (lkNs),
  .fillEn  (fillEn),
  .fillTag (fillTag),
  .fillNs  (fillNs),
  .rspValid(rspValid),
  .rspErr  (rspErr),
  .abortReq(abortReq)
);

// File: tb/test_sec_tlb.sv
`timescale 1ns/1ps
module test_sec_tlb;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic        worldNs;
  logic [31:0] lkVa;
  logic        lkHit;
  logic [31:0] lkPa;
  logic        lkNs;
  logic        walkNs;
  logic        fillEn;
  logic [11:0] fillTag;
  logic [11:0] fillBase;
  logic        fillNs;
  logic        flushWorld;
  logic        flushWorldNs;
  logic        flushAll;
  logic        rspValid;
  logic        rspErr;
  logic        abortReq;

  int checks = 0;
  int errors = 0;

  // Reference state built from the requirements.
  bit          mV   [N];
  bit          mNs  [N];
  bit          mW   [N];
  logic [11:0] mTag [N];
  logic [11:0] mBase[N];
  int          mPtr;

  always #2 clk = ~clk;

  sec_tlb i_sec_tlb (
    .clk(clk), .rstN(rstN), .worldNs(worldNs), .lkVa(lkVa), .lkHit(lkHit),
    .lkPa(lkPa), .lkNs(lkNs), .walkNs(walkNs), .fillEn(fillEn),
    .fillTag(fillTag), .fillBase(fillBase), .fillNs(fillNs),
    .flushWorld(flushWorld), .flushWorldNs(flushWorldNs), .flushAll(flushAll),
    .rspValid(rspValid), .rspErr(rspErr), .abortReq(abortReq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int i = 0; i < N; i++) mV[i] = 0;
    mPtr = 0;
  endtask

  // Apply one clock edge with the given controls, update the model.
  task automatic edgeOp(input bit fe, input logic [11:0] tg,
                        input logic [11:0] bs, input bit dNs, input bit w,
                        input bit fw, input bit fwNs, input bit fa);
    int m;
    bit cs, cn;
    fillEn = fe; fillTag = tg; fillBase = bs; fillNs = dNs; worldNs = w;
    flushWorld = fw; flushWorldNs = fwNs; flushAll = fa;
    @(posedge clk);
    m = -1;
    if (fe) for (int i = 0; i < N; i++)
      if (mV[i] && mTag[i] == tg && mW[i] == w) m = i;
    cs = fa || (fw && !fwNs);
    cn = fa || (fw && fwNs);
    for (int i = 0; i < N; i++)
      if (mV[i] && ((cs && !mW[i]) || (cn && mW[i]))) mV[i] = 0;
    if (fe) begin
      int k;
      k = (m >= 0) ? m : mPtr;
      if (m < 0) mPtr = (mPtr + 1) % N;
      mV[k] = 1; mTag[k] = tg; mBase[k] = bs; mW[k] = w;
      mNs[k] = w ? 1'b1 : dNs;
    end
    @(negedge clk);
    fillEn = 0; flushWorld = 0; flushAll = 0;
  endtask

  task automatic look(input logic [31:0] va, input bit w, input string req);
    bit          eh;
    logic [31:0] ep;
    bit          en;
    eh = 0; ep = '0; en = 1;
    lkVa = va; worldNs = w;
    #1;
    for (int i = 0; i < N; i++)
      if (mV[i] && mTag[i] == va[31:20] && mW[i] == w) begin
        eh = 1; ep = {mBase[i], va[19:0]}; en = mNs[i];
      end
    chk(req, "hit", {31'b0, lkHit}, {31'b0, eh});
    chk(req, "pa", lkPa, ep);
    chk(req, "ns", {31'b0, lkNs}, {31'b0, en});
    chk("R6", "walkNs", {31'b0, walkNs}, {31'b0, w});
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EC7_1B0B));
    rstN = 0; worldNs = 0; lkVa = '0; fillEn = 0; fillTag = '0;
    fillBase = '0; fillNs = 0; flushWorld = 0; flushWorldNs = 0;
    flushAll = 0; rspValid = 0; rspErr = 0;
    modelClear();
    repeat (3) @(negedge clk);
    look(32'h0010_0000, 0, "R11");
    rstN = 1;
    @(negedge clk);

    // R2 R4: secure fill keeps the descriptor bit (0 = secure access)
    edgeOp(1, 12'h001, 12'hABC, 0, 0, 0, 0, 0);
    look(32'h0015_4321, 0, "R4");
    // R3: the same address from the non-secure world misses
    look(32'h0015_4321, 1, "R3");
    // R5: non-secure fill forces the non-secure attribute
    edgeOp(1, 12'h001, 12'h777, 0, 1, 0, 0, 0);
    look(32'h001F_FFFF, 1, "R5");
    look(32'h001F_FFFF, 0, "R3");
    // R7: overwrite of the secure entry with a new base and NS=1
    edgeOp(1, 12'h001, 12'h123, 1, 0, 0, 0, 0);
    look(32'h0010_0004, 0, "R7");
    // R9: flush the secure world only
    edgeOp(0, 12'h0, 12'h0, 0, 0, 1, 0, 0);
    look(32'h0010_0004, 0, "R9");
    look(32'h0010_0004, 1, "R9");
    // R10: flush-all together with a fill, and overwrite while flushed
    edgeOp(1, 12'h001, 12'h456, 0, 1, 0, 0, 1);
    look(32'h0010_0000, 1, "R10");
    edgeOp(1, 12'h002, 12'h111, 0, 0, 0, 0, 1);
    look(32'h0020_0000, 0, "R10");
    look(32'h0010_0000, 1, "R10");
    // R8: nine distinct fills, the oldest is replaced
    edgeOp(0, 12'h0, 12'h0, 0, 0, 0, 0, 1);
    for (int t = 0; t < 9; t++)
      edgeOp(1, 12'h100 + 12'(t), 12'h200 + 12'(t), 1, 0, 0, 0, 0);
    for (int t = 0; t < 9; t++)
      look({12'h100 + 12'(t), 20'h0_0ABC}, 0, "R8");
    // R12: error response raises a one-cycle abort, no other effect
    rspValid = 1; rspErr = 1;
    @(negedge clk);
    rspValid = 0; rspErr = 0;
    chk("R12", "abort", {31'b0, abortReq}, 32'd1);
    @(negedge clk);
    chk("R12", "abort drop", {31'b0, abortReq}, 32'd0);
    rspValid = 1; rspErr = 0;
    @(negedge clk);
    rspValid = 0;
    chk("R12", "no abort", {31'b0, abortReq}, 32'd0);
    look({12'h108, 20'h0_0001}, 0, "R12");

    // R1: random mix of fills, flushes and lookups
    for (int it = 0; it < 3000; it++) begin
      int op;
      op = $urandom_range(0, 99);
      if (op < 40)
        edgeOp(1, 12'($urandom_range(0, 11)), 12'($urandom),
               1'($urandom), 1'($urandom), 0, 0, 0);
      else if (op < 45)
        edgeOp(1'($urandom), 12'($urandom_range(0, 11)), 12'($urandom),
               1'($urandom), 1'($urandom), 1, 1'($urandom), 0);
      else if (op < 47)
        edgeOp(1'($urandom), 12'($urandom_range(0, 11)), 12'($urandom),
               1'($urandom), 1'($urandom), 0, 0, 1);
      else
        look({12'($urandom_range(0, 11)), 20'($urandom)}, 1'($urandom), "R1");
    end

    // R11: reset mid-run clears entries and the pointer
    rstN = 0;
    @(negedge clk);
    rstN = 1;
    modelClear();
    look(32'h0030_0000, 0, "R11");
    edgeOp(1, 12'h00A, 12'h0AA, 0, 0, 0, 0, 0);
    look(32'h00A0_0000, 0, "R11");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule